// File: doc/BRIEF.md
# Triangular Carrier Timebase for Three-Phase PWM

This block produces the shared up/down carrier used to time a three-phase motor PWM stage. A counter rises one step per clock from a floor equal to twice the dead-time setting up to a ceiling equal to the period setting plus twice the dead time. It then falls back to the floor, and keeps bouncing between the two points for as long as the run input stays high. Each turnaround value is shown for exactly one cycle, and a registered direction flag reports which way the count is moving.

The count is compared on every cycle against three sets of per-phase registers. The common set matches in either direction. The rising set, together with the period value, matches only while the count is rising. The falling set, together with the floor value, matches only while it is falling. Every match is a single-cycle strobe. When run is low, the counter parks at the floor with the flag set to rising and all strobes stay low.

To stop the timer safely, software drives the PWM pin high, hands the pin back to port control, and only then drops run. This block sees only the final step.

Top module: `tri_carrier_timebase`

## Requirements
- R1: While rst_n is low, count is 0, dir_up is 1 (1 means rising) and every match output is 0.
- R2: While run is low, every match output is 0. At each clock edge with run low, count loads 2*dead_time and dir_up becomes 1.
- R3: While rising below the ceiling (period + 2*dead_time), count increases by exactly 1 per clock.
- R4: When count equals the ceiling while rising and the ceiling exceeds the floor, that value lasts one cycle. On the next cycle dir_up is 0 and count is the ceiling minus 1.
- R5: When count falls to the floor (2*dead_time), that value lasts one cycle. On the next cycle dir_up is 1 and count is the floor plus 1. This cycle repeats with no end.
- R6: match_com[i] is 1 in exactly the cycles where run is high and count equals cmp_com[i], in either direction.
- R7: match_up[i] is 1 exactly when run is high, dir_up is 1 and count equals cmp_up[i]. match_per is 1 exactly when run is high, dir_up is 1 and count equals period (zero-extended).
- R8: match_dn[i] is 1 exactly when run is high, dir_up is 0 and count equals cmp_dn[i]. match_floor is 1 exactly when run is high, dir_up is 0 and count equals 2*dead_time.
- R9: When period is 0 and run is high, count holds at the floor and dir_up stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = carrier runs, 0 = park at floor |
| dead_time | input | DW | Dead-time setting; floor is twice this value |
| period | input | DW | Period setting; ceiling is this plus the floor |
| cmp_com | input | NPH x (DW+2) | Per-phase compares, both directions |
| cmp_up | input | NPH x (DW+2) | Per-phase compares, rising only |
| cmp_dn | input | NPH x (DW+2) | Per-phase compares, falling only |
| count | output | DW+2 | Carrier count |
| dir_up | output | 1 | Direction flag, 1 = rising |
| match_com | output | NPH | Common-compare strobes, bit i is phase i |
| match_up | output | NPH | Rising-compare strobes |
| match_dn | output | NPH | Falling-compare strobes |
| match_per | output | 1 | Count equals period while rising |
| match_floor | output | 1 | Count equals floor while falling |

## Verification
Count and dir_up are registered, so a change on run, dead_time or period appears on them one clock edge later. The match strobes are combinational from the registered count and flag and from the live compare inputs, so they are valid within the same cycle. The bench drives inputs at the falling edge. It reads strobes just after that edge, and it reads count and flag at the next falling edge, which is exactly one rising edge after the stimulus. The expected carrier position is computed from a closed-form triangle in the step index, with no stepping model.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/tc_bounds.sv
module tc_bounds #(
  parameter int DW   = 16,
  parameter int CNTW = DW + 2
) (
  input  logic [DW-1:0]   dead_time,
  input  logic [DW-1:0]   period,
  output logic [CNTW-1:0] floor_o,
  output logic [CNTW-1:0] ceil_o,
  output logic [CNTW-1:0] per_o
);
  function automatic logic [CNTW-1:0] floor_of(input logic [DW-1:0] dt);
    return {1'b0, dt, 1'b0};
  endfunction

  function automatic logic [CNTW-1:0] widen(input logic [DW-1:0] v);
    return {2'b00, v};
  endfunction

  function automatic logic [CNTW-1:0] ceil_of(input logic [DW-1:0] per,
                                               input logic [CNTW-1:0] fl);
    return widen(per) + fl;
  endfunction

  always_comb begin
    floor_o = floor_of(dead_time);
    per_o   = widen(period);
    ceil_o  = ceil_of(period, floor_o);
  end
endmodule

// File: rtl/tc_ramp.sv
module tc_ramp
  import tc_pkg::*;
#(
  parameter int CNTW = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [CNTW-1:0] floor_i,
  input  logic [CNTW-1:0] ceil_i,
  output logic [CNTW-1:0] count_o,
  output logic            dir_up_o,
  output logic            at_top_o,
  output logic            at_bot_o
);
  logic [CNTW-1:0] cnt_q, cnt_d;
  dir_e            dir_q, dir_d;
  logic            flat;

  always_comb begin
    at_top_o = (dir_q == DIR_UP)   && (cnt_q >= ceil_i);
    at_bot_o = (dir_q == DIR_DOWN) && (cnt_q <= floor_i);
    flat     = (ceil_i == floor_i);
    cnt_d    = cnt_q;
    dir_d    = dir_q;
    if (!run) begin
      cnt_d = floor_i;
      dir_d = DIR_UP;
    end else if (at_top_o) begin
      if (flat) begin
        cnt_d = ceil_i;
        dir_d = DIR_UP;
      end else begin
        cnt_d = cnt_q - 1'b1;
        dir_d = DIR_DOWN;
      end
    end else if (at_bot_o) begin
      cnt_d = cnt_q + 1'b1;
      dir_d = DIR_UP;
    end else if (dir_q == DIR_UP) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign count_o  = cnt_q;
  assign dir_up_o = (dir_q == DIR_UP);
endmodule

// File: rtl/tc_compare.sv
module tc_compare #(
  parameter int NPH  = 3,
  parameter int CNTW = 18
) (
  input  logic                     run,
  input  logic                     dir_up,
  input  logic [CNTW-1:0]          count,
  input  logic [CNTW-1:0]          floor_i,
  input  logic [CNTW-1:0]          per_i,
  input  logic [NPH-1:0][CNTW-1:0] cmp_com,
  input  logic [NPH-1:0][CNTW-1:0] cmp_up,
  input  logic [NPH-1:0][CNTW-1:0] cmp_dn,
  output logic [NPH-1:0]           match_com,
  output logic [NPH-1:0]           match_up,
  output logic [NPH-1:0]           match_dn,
  output logic                     match_per,
  output logic                     match_floor
);
  function automatic logic hit(input logic en, input logic [CNTW-1:0] a,
                               input logic [CNTW-1:0] b);
    return en && (a == b);
  endfunction

  logic en_any, en_rise, en_fall;
  assign en_any  = run;
  assign en_rise = run && dir_up;
  assign en_fall = run && !dir_up;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    assign match_com[p] = hit(en_any,  count, cmp_com[p]);
    assign match_up[p]  = hit(en_rise, count, cmp_up[p]);
    assign match_dn[p]  = hit(en_fall, count, cmp_dn[p]);
  end

  assign match_per   = hit(en_rise, count, per_i);
  assign match_floor = hit(en_fall, count, floor_i);
endmodule

// File: rtl/tri_carrier_timebase.sv
module tri_carrier_timebase #(
  parameter int DW   = 16,
  parameter int NPH  = 3,
  localparam int CNTW = DW + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [DW-1:0]            dead_time,
  input  logic [DW-1:0]            period,
  input  logic [NPH-1:0][CNTW-1:0] cmp_com,
  input  logic [NPH-1:0][CNTW-1:0] cmp_up,
  input  logic [NPH-1:0][CNTW-1:0] cmp_dn,
  output logic [CNTW-1:0]          count,
  output logic                     dir_up,
  output logic [NPH-1:0]           match_com,
  output logic [NPH-1:0]           match_up,
  output logic [NPH-1:0]           match_dn,
  output logic                     match_per,
  output logic                     match_floor
);
  logic [CNTW-1:0] floor_w, ceil_w, per_w;
  logic            turn_top, turn_bot;

  tc_bounds #(.DW(DW), .CNTW(CNTW)) u_bounds (
    .dead_time (dead_time),
    .period    (period),
    .floor_o   (floor_w),
    .ceil_o    (ceil_w),
    .per_o     (per_w)
  );

  tc_ramp #(.CNTW(CNTW)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .floor_i  (floor_w),
    .ceil_i   (ceil_w),
    .count_o  (count),
    .dir_up_o (dir_up),
    .at_top_o (turn_top),
    .at_bot_o (turn_bot)
  );

  tc_compare #(.NPH(NPH), .CNTW(CNTW)) u_cmp (
    .run         (run),
    .dir_up      (dir_up),
    .count       (count),
    .floor_i     (floor_w),
    .per_i       (per_w),
    .cmp_com     (cmp_com),
    .cmp_up      (cmp_up),
    .cmp_dn      (cmp_dn),
    .match_com   (match_com),
    .match_up    (match_up),
    .match_dn    (match_dn),
    .match_per   (match_per),
    .match_floor (match_floor)
  );
endmodule

// File: rtl/tc_timebase_chk.sv
module tc_timebase_chk #(
  parameter int CNTW = 18,
  parameter int NPH  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic [CNTW-1:0] count,
  input logic            dir_up,
  input logic [CNTW-1:0] floor_w,
  input logic [CNTW-1:0] ceil_w,
  input logic            turn_top,
  input logic            turn_bot,
  input logic [NPH-1:0]  match_com,
  input logic [NPH-1:0]  match_up,
  input logic [NPH-1:0]  match_dn,
  input logic            match_per,
  input logic            match_floor
);
  p_idle_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == $past(floor_w)) && dir_up);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (match_com == '0) && (match_up == '0) && (match_dn == '0)
             && !match_per && !match_floor);

  p_rise_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dir_up && count < ceil_w) |=> count == $past(count) + CNTW'(1));

  p_top_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && turn_top && ceil_w != floor_w) |=> !dir_up);

  p_bottom_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && turn_bot) |=> dir_up && count == $past(count) + CNTW'(1));

  p_rise_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_up != '0) || match_per) |-> dir_up);

  p_fall_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_dn != '0) || match_floor) |-> !dir_up);

  p_flat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && turn_top && ceil_w == floor_w) |=> dir_up && count == $past(ceil_w));
endmodule

bind tri_carrier_timebase tc_timebase_chk #(.CNTW(CNTW), .NPH(NPH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .count       (count),
  .dir_up      (dir_up),
  .floor_w     (floor_w),
  .ceil_w      (ceil_w),
  .turn_top    (turn_top),
  .turn_bot    (turn_bot),
  .match_com   (match_com),
  .match_up    (match_up),
  .match_dn    (match_dn),
  .match_per   (match_per),
  .match_floor (match_floor)
);

// File: tb/test_tri_carrier_timebase.sv
module test_tri_carrier_timebase;
  localparam int DW   = 16;
  localparam int NPH  = 3;
  localparam int CNTW = DW + 2;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     run = 1'b0;
  logic [DW-1:0]            dead_time = '0;
  logic [DW-1:0]            period = '0;
  logic [NPH-1:0][CNTW-1:0] cmp_com = '0;
  logic [NPH-1:0][CNTW-1:0] cmp_up = '0;
  logic [NPH-1:0][CNTW-1:0] cmp_dn = '0;
  logic [CNTW-1:0]          count;
  logic                     dir_up;
  logic [NPH-1:0]           match_com, match_up, match_dn;
  logic                     match_per, match_floor;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  tri_carrier_timebase #(.DW(DW), .NPH(NPH)) i_tri_carrier_timebase (
    .clk(clk), .rst_n(rst_n), .run(run), .dead_time(dead_time), .period(period),
    .cmp_com(cmp_com), .cmp_up(cmp_up), .cmp_dn(cmp_dn), .count(count),
    .dir_up(dir_up), .match_com(match_com), .match_up(match_up),
    .match_dn(match_dn), .match_per(match_per), .match_floor(match_floor)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Triangle position k steps after run rises at the floor
  function automatic longint tri_count(longint fl, longint p, int k);
    longint ph = k % (2 * p);
    return (ph <= p) ? fl + ph : fl + 2 * p - ph;
  endfunction

  function automatic bit tri_rising(longint p, int k);
    longint ph = k % (2 * p);
    if (k == 0) return 1'b1;
    return (ph >= 1 && ph <= p);
  endfunction

  task automatic check_quiet(input string req);
    chk(req, "match_com", match_com, 0);
    chk(req, "match_up", match_up, 0);
    chk(req, "match_dn", match_dn, 0);
    chk(req, "match_per", match_per, 0);
    chk(req, "match_floor", match_floor, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "count", count, 0);
    chk("R1", "dir_up", dir_up, 1);
    check_quiet("R1");
    rst_n = 1'b1;
  endtask

  task automatic t_sweep(input int dt, input int per,
                         input logic [NPH-1:0][CNTW-1:0] cc,
                         input logic [NPH-1:0][CNTW-1:0] cu,
                         input logic [NPH-1:0][CNTW-1:0] cd,
                         input int steps);
    longint fl = 2 * dt;
    @(negedge clk);
    run = 1'b0; dead_time = DW'(dt); period = DW'(per);
    cmp_com = cc; cmp_up = cu; cmp_dn = cd;
    @(negedge clk);
    chk("R2", "idle count", count, fl);
    chk("R2", "idle dir_up", dir_up, 1);
    check_quiet("R2");
    run = 1'b1;
    #1;
    for (int k = 0; k <= steps; k++) begin
      longint ec;
      bit     er;
      longint ph;
      string  tag;
      if (k > 0) begin
        @(negedge clk);
        #1;
      end
      ec = tri_count(fl, per, k);
      er = tri_rising(per, k);
      ph = k % (2 * per);
      tag = (k > 0 && ph == 0) ? "R5" : (ph > per) ? "R4" : "R3";
      chk(tag, "count", count, ec);
      chk(tag, "dir_up", dir_up, er);
      for (int i = 0; i < NPH; i++) begin
        chk("R6", "match_com", match_com[i], ec == cc[i]);
        chk("R7", "match_up", match_up[i], er && ec == cu[i]);
        chk("R8", "match_dn", match_dn[i], !er && ec == cd[i]);
      end
      chk("R7", "match_per", match_per, er && ec == per);
      chk("R8", "match_floor", match_floor, !er && ec == fl);
    end
  endtask

  task automatic t_stop();
    longint fl = 2 * longint'(dead_time);
    @(negedge clk);
    cmp_com[0] = count;
    run = 1'b0;
    #1;
    check_quiet("R2");
    @(negedge clk);
    chk("R2", "stop count", count, fl);
    chk("R2", "stop dir_up", dir_up, 1);
  endtask

  task automatic t_flat(input int dt);
    @(negedge clk);
    run = 1'b0; dead_time = DW'(dt); period = '0;
    @(negedge clk);
    run = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      chk("R9", "flat count", count, 2 * dt);
      chk("R9", "flat dir_up", dir_up, 1);
      chk("R9", "flat match_floor", match_floor, 0);
    end
    run = 1'b0;
  endtask

  initial begin
    t_reset();
    t_sweep(2, 5, {18'd4, 18'd9, 18'd6}, {18'd9, 18'd7, 18'd5},
            {18'd4, 18'd7, 18'd8}, 25);
    t_sweep(0, 3, {18'd2, 18'd3, 18'd0}, {18'd3, 18'd1, 18'd0},
            {18'd1, 18'd2, 18'd0}, 14);
    t_stop();
    t_flat(3);
    t_sweep(100, 7, {18'd200, 18'd207, 18'd203}, {18'd205, 18'd7, 18'd201},
            {18'd203, 18'd206, 18'd300}, 16);
    t_stop();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule